// File: doc/BRIEF.md
# Dual-channel DAC serial command register bank

This block is the digital front end of a two-channel 10-bit converter. A host sends 16-bit command words over a three-wire serial link: a serial clock, a serial data line and an active-low select line. The block brings these lines into the system clock domain and assembles each word. It then applies the 4-bit command carried in the word to a double-buffered register set. Each channel has a staging register and an output register that the converter reads. The block also holds a sleep flag for the converter.

Staging registers can be loaded with no visible effect. The two outputs can then be updated together, or one channel can be loaded and both outputs updated in the same command. A single command can also write the same code to both channels. After each complete word the serial input is shut off until the select line falls again. Extra clock pulses in that window therefore cannot corrupt the registers.

The serial link has no valid/ready handshake and no back-pressure. The host paces the words, and every complete word is applied as a single-cycle strobe one system clock after its last bit is recognised.

Top module: `dac_ctrl_bank`

## Requirements
- R1: Reset state. After reset, output A is 10'b1110101111 (0x3AF) and output B is 10'b0000101000 (0x028). Staging A and staging B hold the same two values, and `asleep` is 0.
- R2: Command 4'b0001 writes the data field into staging A, and command 4'b0010 writes it into staging B. Neither command changes either output or `asleep`.
- R3: Command 4'b1000 copies staging A to output A and staging B to output B, then clears `asleep`.
- R4: Command 4'b1001 writes the data into staging A and output A, copies staging B to output B, and clears `asleep`. Command 4'b1010 writes the data into staging B and output B, copies staging A to output A, and clears `asleep`.
- R5: Command 4'b1110 sets `asleep` and command 4'b1101 clears it. Neither changes any register.
- R6: Command 4'b1111 writes the data into both staging registers and both outputs, and clears `asleep`.
- R7: Command 4'b0000 and the unused commands 0011, 0100, 0101, 0110, 0111, 1011 and 1100 change no register and leave `asleep` as it was.
- R8: A word takes effect only after 16 rising serial clock edges while `cs_n` is low. If `cs_n` rises before the 16th edge, the partial word is dropped and nothing changes.
- R9: After the 16th edge, further serial clock and data activity is ignored until the next falling edge of `cs_n`.
- R10: Word format. Bits are shifted most significant first, on rising `sclk`. Bits [15:12] hold the command, bits [11:2] hold the data, and bits [1:0] are ignored.
- R11: The outputs and `asleep` change only in the cycle after a command strobe, and a strobe never lasts more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, asynchronous to clk |
| sdata | input | 1 | Serial data, sampled on rising sclk |
| cs_n | input | 1 | Active-low select/load line |
| dac_a | output | 10 | Output register of channel A |
| dac_b | output | 10 | Output register of channel B |
| asleep | output | 1 | 1 while the converter is in sleep |

## Verification
Several properties are checked on every cycle. The outputs and the sleep flag must hold steady unless a command strobe fired, and the strobe must be a single cycle. The sleep flag may only rise after a sleep command. Load-only commands must leave the outputs alone, and the broadcast command must leave both outputs equal. The bench scenarios cover the rest. Staging contents are only visible after a later update command. Only a bench scenario can show that partial words are dropped, that bits after the 16th are ignored, and that the unused codes leave everything unchanged.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
  localparam int unsigned CODE_W = 4;
  localparam logic [CODE_W-1:0] OP_NOP      = 4'b0000;
  localparam logic [CODE_W-1:0] OP_STAGE_A  = 4'b0001;
  localparam logic [CODE_W-1:0] OP_STAGE_B  = 4'b0010;
  localparam logic [CODE_W-1:0] OP_COMMIT   = 4'b1000;
  localparam logic [CODE_W-1:0] OP_A_COMMIT = 4'b1001;
  localparam logic [CODE_W-1:0] OP_B_COMMIT = 4'b1010;
  localparam logic [CODE_W-1:0] OP_WAKE     = 4'b1101;
  localparam logic [CODE_W-1:0] OP_SLEEP    = 4'b1110;
  localparam logic [CODE_W-1:0] OP_BOTH     = 4'b1111;
endpackage

// File: rtl/dcb_sync.sv
module dcb_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_in,
  output logic [N-1:0] q_out
);
  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d_in;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= RST_VAL;
      else        stg[g] <= stg[g-1];
    end
  end

  assign q_out = stg[STAGES-1];
endmodule

// File: rtl/dcb_shift.sv
module dcb_shift #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned KEEP_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              sdi_s,
  input  logic              csn_s,
  output logic [KEEP_W-1:0] word_o,
  output logic              strobe_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);

  logic              sck_d, csn_d, armed;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-2:0] shreg;
  logic [WORD_W-1:0] next_word;

  assign next_word = {shreg, sdi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d    <= 1'b0;
      csn_d    <= 1'b1;
      armed    <= 1'b0;
      cnt      <= '0;
      shreg    <= '0;
      word_o   <= '0;
      strobe_o <= 1'b0;
    end else begin
      sck_d    <= sck_s;
      csn_d    <= csn_s;
      strobe_o <= 1'b0;
      if (csn_d && !csn_s) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (csn_s) begin
        armed <= 1'b0;
      end else if (armed && sck_s && !sck_d) begin
        shreg <= next_word[WORD_W-2:0];
        cnt   <= cnt + 1'b1;
        if (cnt == CNT_W'(WORD_W-1)) begin
          word_o   <= next_word[WORD_W-1 -: KEEP_W];
          strobe_o <= 1'b1;
          armed    <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dcb_bank.sv
module dcb_bank
  import dcb_pkg::*;
#(
  parameter int unsigned DW = 10,
  parameter logic [DW-1:0] RST_A = 10'b1110101111,
  parameter logic [DW-1:0] RST_B = 10'b0000101000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [CODE_W-1:0] code,
  input  logic [DW-1:0]     data,
  output logic [DW-1:0]     dac_a,
  output logic [DW-1:0]     dac_b,
  output logic              asleep
);
  logic [DW-1:0] stage_a, stage_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_a <= RST_A;
      stage_b <= RST_B;
      dac_a   <= RST_A;
      dac_b   <= RST_B;
      asleep  <= 1'b0;
    end else if (strobe) begin
      case (code)
        OP_STAGE_A: stage_a <= data;
        OP_STAGE_B: stage_b <= data;
        OP_COMMIT: begin
          dac_a  <= stage_a;
          dac_b  <= stage_b;
          asleep <= 1'b0;
        end
        OP_A_COMMIT: begin
          stage_a <= data;
          dac_a   <= data;
          dac_b   <= stage_b;
          asleep  <= 1'b0;
        end
        OP_B_COMMIT: begin
          stage_b <= data;
          dac_b   <= data;
          dac_a   <= stage_a;
          asleep  <= 1'b0;
        end
        OP_WAKE:  asleep <= 1'b0;
        OP_SLEEP: asleep <= 1'b1;
        OP_BOTH: begin
          stage_a <= data;
          stage_b <= data;
          dac_a   <= data;
          dac_b   <= data;
          asleep  <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dac_ctrl_bank.sv
module dac_ctrl_bank
  import dcb_pkg::*;
#(
  parameter int unsigned DW          = 10,
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [DW-1:0] RST_A = 10'b1110101111,
  parameter logic [DW-1:0] RST_B = 10'b0000101000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          sdata,
  input  logic          cs_n,
  output logic [DW-1:0] dac_a,
  output logic [DW-1:0] dac_b,
  output logic          asleep
);
  localparam int unsigned KEEP_W = CODE_W + DW;

  logic [2:0]          pins_s;
  logic [KEEP_W-1:0]   cmd_word;
  logic                cmd_vld;
  logic [CODE_W-1:0]   cmd_code;
  logic [DW-1:0]       cmd_data;

  dcb_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({cs_n, sdata, sclk}),
    .q_out (pins_s)
  );

  dcb_shift #(.WORD_W(WORD_W), .KEEP_W(KEEP_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_s    (pins_s[0]),
    .sdi_s    (pins_s[1]),
    .csn_s    (pins_s[2]),
    .word_o   (cmd_word),
    .strobe_o (cmd_vld)
  );

  assign cmd_code = cmd_word[KEEP_W-1 -: CODE_W];
  assign cmd_data = cmd_word[DW-1:0];

  dcb_bank #(.DW(DW), .RST_A(RST_A), .RST_B(RST_B)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (cmd_vld),
    .code   (cmd_code),
    .data   (cmd_data),
    .dac_a  (dac_a),
    .dac_b  (dac_b),
    .asleep (asleep)
  );
endmodule

// File: rtl/dcb_checker.sv
module dcb_checker #(
  parameter int unsigned DW = 10,
  parameter logic [DW-1:0] RST_A = 10'b1110101111,
  parameter logic [DW-1:0] RST_B = 10'b0000101000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          strobe,
  input logic [3:0]    code,
  input logic [DW-1:0] dac_a,
  input logic [DW-1:0] dac_b,
  input logic          asleep
);
  a_r1_reset_values: assert property (@(posedge clk)
    !rst_n |=> (dac_a == RST_A && dac_b == RST_B && !asleep));

  a_r11_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> ($stable(dac_a) && $stable(dac_b) && $stable(asleep)));

  a_r11_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

  a_r5_sleep_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> ($past(strobe) && $past(code) == 4'b1110));

  a_r2_stage_only: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && (code == 4'b0001 || code == 4'b0010))
      |=> ($stable(dac_a) && $stable(dac_b) && $stable(asleep)));

  a_r6_broadcast_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && code == 4'b1111) |=> (dac_a == dac_b && !asleep));
endmodule

bind dac_ctrl_bank dcb_checker #(.DW(DW), .RST_A(RST_A), .RST_B(RST_B)) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .strobe (cmd_vld),
  .code   (cmd_code),
  .dac_a  (dac_a),
  .dac_b  (dac_b),
  .asleep (asleep)
);

// File: tb/dac_ctrl_bank_tb_top.sv
module dac_ctrl_bank_tb_top;
  localparam int HP = 3;
  localparam logic [9:0] RA = 10'h3AF;
  localparam logic [9:0] RB = 10'h028;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, cs_n = 1'b1;
  logic [9:0] dac_a, dac_b;
  logic asleep;

  int checks = 0;
  int errors = 0;

  logic [9:0] m_sa, m_sb, m_da, m_db;
  logic       m_sl;

  always #2 clk = ~clk;

  dac_ctrl_bank dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .cs_n(cs_n),
    .dac_a(dac_a), .dac_b(dac_b), .asleep(asleep)
  );

  function automatic logic [15:0] mk(input logic [3:0] c, input logic [9:0] d);
    return {c, d, 2'($urandom_range(0, 3))};
  endfunction

  task automatic model(input logic [15:0] w);
    logic [3:0] c = w[15:12];
    logic [9:0] d = w[11:2];
    case (c)
      4'b0001: m_sa = d;
      4'b0010: m_sb = d;
      4'b1000: begin m_da = m_sa; m_db = m_sb; m_sl = 1'b0; end
      4'b1001: begin m_sa = d; m_da = d; m_db = m_sb; m_sl = 1'b0; end
      4'b1010: begin m_sb = d; m_db = d; m_da = m_sa; m_sl = 1'b0; end
      4'b1101: m_sl = 1'b0;
      4'b1110: m_sl = 1'b1;
      4'b1111: begin m_sa = d; m_sb = d; m_da = d; m_db = d; m_sl = 1'b0; end
      default: ;
    endcase
  endtask

  task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " dac_a"}, dac_a, m_da);
    chk({tag, " dac_b"}, dac_b, m_db);
    chk({tag, " asleep"}, {9'd0, asleep}, {9'd0, m_sl});
  endtask

  task automatic frame(input logic [15:0] w, input int nbits, input logic [7:0] tail);
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdata = (i < 16) ? w[15-i] : tail[i % 8];
      repeat (HP) @(negedge clk);
      sclk = 1'b1;
      repeat (HP) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HP) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
    if (nbits >= 16) model(w);
  endtask

  task automatic send(input logic [15:0] w);
    frame(w, 16, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    m_sa = RA; m_sb = RB; m_da = RA; m_db = RB; m_sl = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_all("R1 reset");

    send(mk(4'b1000, 10'h111));
    chk_all("R1 R3 commit after reset");

    send(mk(4'b0001, 10'h155));
    chk_all("R2 stage A hidden");
    send(mk(4'b0010, 10'h0AA));
    chk_all("R2 stage B hidden");
    send(mk(4'b1000, 10'h000));
    chk_all("R3 commit both");

    send(mk(4'b1110, 10'h3FF));
    chk_all("R5 sleep");
    send(mk(4'b0001, 10'h201));
    chk_all("R2 status kept asleep");
    send(mk(4'b1101, 10'h000));
    chk_all("R5 wake");

    send(mk(4'b1110, 10'h000));
    send(mk(4'b1001, 10'h2C3));
    chk_all("R4 load A and commit");
    send(mk(4'b0001, 10'h0F0));
    send(mk(4'b1010, 10'h30C));
    chk_all("R4 load B and commit");

    foreach (m_sa[i]) begin end
    send(mk(4'b0011, 10'h001)); send(mk(4'b0100, 10'h002));
    send(mk(4'b0101, 10'h004)); send(mk(4'b0110, 10'h008));
    send(mk(4'b0111, 10'h010)); send(mk(4'b1011, 10'h020));
    send(mk(4'b1100, 10'h040)); send(mk(4'b0000, 10'h080));
    chk_all("R7 unused codes no effect");
    send(mk(4'b1000, 10'h000));
    chk_all("R7 staging untouched");

    frame(16'hF000 | 16'(10'h155 << 2), 10, 8'h00);
    chk_all("R8 short frame dropped");
    send(mk(4'b1000, 10'h000));
    chk_all("R8 staging untouched");

    frame({4'b1111, 10'h201, 2'b11}, 22, 8'h00);
    chk_all("R9 R6 R10 broadcast with extra edges");
    frame({4'b1001, 10'h3FE, 2'b00}, 20, 8'hFF);
    chk_all("R9 R10 extra ones ignored");

    for (int k = 0; k < 60; k++) begin
      logic [3:0] c = 4'($urandom_range(0, 15));
      if (k % 5 == 0) c = 4'b1000;
      send(mk(c, 10'($urandom)));
      chk_all($sformatf("R2 R3 R4 R5 R6 R7 random op %b", c));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule